// File: doc/BRIEF.md
# DMA Register Frontend

This block sits on a processor's simple request/grant bus as a slave and turns a handful of configuration registers into a one-dimensional DMA request for the next stage of a DMA engine. Software first programs a source address and a destination address. It then writes the transfer length, and that write launches the transfer. There is no separate start bit and no list of queued transfers. Only one transfer is outstanding at a time.

When the length is written, the block freezes source, destination and length into a request payload. It raises a valid/ready request toward the downstream stage and keeps it up until that stage accepts it. Three read-only registers let software follow progress:
- a flag showing that the command has been handed on;
- the downstream busy vector, passed through as received;
- a sticky flag showing that the transfer has finished.

Register index is the byte address divided by four. Index 1 holds the length, 2 the source and 3 the destination. Index 4 is the forwarded flag in bit 0, index 5 the busy vector and index 6 the done flag in bit 0. Every other index reads as zero.

Top module: `dma_cfg_front`

## Requirements
- R1: Every bus request is granted in the same cycle (`bus_gnt_o` follows `bus_req_i`), and `bus_rvalid_o` is high in exactly the cycle after each granted request.
- R2: The register index is `bus_addr_i[11:2]`, and address bits 1:0 are ignored. Reads of index 2 (source) and index 3 (destination) return the last value written. A read of index 1 returns the length of the last launched transfer. All of these read zero after reset. Write responses carry zero data.
- R3: Indexes 0 and 7 and above read as zero, and writes to them change no register.
- R4: A write to index 1 while the block is idle launches a transfer. From the next cycle `xfer_valid_o` is high, carrying the written length and the source and destination register values of the write cycle.
- R5: While `xfer_valid_o` is high and `xfer_ready_i` is low, the request stays valid and its source, destination and length hold steady.
- R6: The forwarded flag (index 4, bit 0) reads 1 from the cycle after the valid/ready handshake. A new launch clears it, and it reads 0 after reset.
- R7: A read of index 5 returns `busy_i` as it was in the request cycle, zero-extended to 32 bits.
- R8: The done flag (index 6, bit 0) is set in the cycle after `done_i` is seen high while the forwarded flag is 1. It stays set until the next launch clears it, and it reads 0 after reset.
- R9: A length write is ignored while a request is pending, or while a transfer has been forwarded but is not yet done. Such a write raises no new request and leaves the index 1 value unchanged.
- R10: Writes to indexes 4, 5 and 6 have no effect on the values read there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Bus request |
| bus_we_i | input | 1 | Bus write enable (1 = write) |
| bus_addr_i | input | 12 | Bus byte address |
| bus_wdata_i | input | 32 | Bus write data |
| bus_gnt_o | output | 1 | Bus grant |
| bus_rvalid_o | output | 1 | Bus response valid |
| bus_rdata_o | output | 32 | Bus read data |
| xfer_valid_o | output | 1 | Transfer request valid |
| xfer_ready_i | input | 1 | Transfer request accepted by the next stage |
| xfer_src_o | output | 32 | Request source address |
| xfer_dst_o | output | 32 | Request destination address |
| xfer_len_o | output | 32 | Request length |
| busy_i | input | 8 | Backend busy vector |
| done_i | input | 1 | Transfer completion indication |

## Verification
The assertions assume that the bus master holds no request open across cycles. They also assume that `done_i` means something only after a request has been forwarded, which is why the done property is conditioned on the forwarded flag. The stimulus keeps to this. Each bus request lasts one cycle, and requests are separated by at least one idle cycle. `done_i` and `busy_i` are changed only at the falling edge. `xfer_ready_i` is held low across several cycles to show that the request persists, and is raised only while a request is pending or idle. A behavioural model in the bench follows every cycle, so the checks also catch early completion pulses and ignored length writes.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

  localparam int unsigned NREG = 7;

  typedef enum logic [2:0] {
    IDX_NONE = 3'd0,
    IDX_LEN  = 3'd1,
    IDX_SRC  = 3'd2,
    IDX_DST  = 3'd3,
    IDX_FWD  = 3'd4,
    IDX_BUSY = 3'd5,
    IDX_DONE = 3'd6
  } reg_idx_e;

endpackage

// File: rtl/dma_cfg_decode.sv
module dma_cfg_decode
  import dma_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NREG-1:0]   sel_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  assign idx = addr_i[ADDR_W-1:2];

  // one select line per mapped index; line 0 collects everything unmapped
  for (genvar g = 1; g < NREG; g++) begin : g_sel
    assign sel_o[g] = (idx == IDX_W'(g));
  end

  assign sel_o[0] = ~|sel_o[NREG-1:1];

endmodule

// File: rtl/dma_cfg_launch.sv
module dma_cfg_launch #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_len_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              ready_i,
  input  logic              done_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] src_o,
  output logic [DATA_W-1:0] dst_o,
  output logic [DATA_W-1:0] len_o,
  output logic              fwd_o,
  output logic              done_o,
  output logic              lock_o
);

  logic pend_q, pend_d;
  logic fwd_q, fwd_d;
  logic done_q, done_d;
  logic launch, hshake;
  logic [DATA_W-1:0] src_q, dst_q, len_q;

  assign lock_o = pend_q | (fwd_q & ~done_q);
  assign launch = wr_len_i & ~lock_o;
  assign hshake = pend_q & ready_i;

  always_comb begin
    pend_d = pend_q;
    fwd_d  = fwd_q;
    done_d = done_q;
    if (launch) begin
      pend_d = 1'b1;
      fwd_d  = 1'b0;
      done_d = 1'b0;
    end else begin
      if (hshake) begin
        pend_d = 1'b0;
        fwd_d  = 1'b1;
      end
      if (fwd_q && done_i) begin
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      fwd_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      fwd_q  <= fwd_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      len_q <= '0;
    end else if (launch) begin
      src_q <= src_i;
      dst_q <= dst_i;
      len_q <= wdata_i;
    end
  end

  assign valid_o = pend_q;
  assign src_o   = src_q;
  assign dst_o   = dst_q;
  assign len_o   = len_q;
  assign fwd_o   = fwd_q;
  assign done_o  = done_q;

endmodule

// File: rtl/dma_cfg_rdmux.sv
module dma_cfg_rdmux
  import dma_cfg_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BUSY_W = 8
) (
  input  logic [NREG-1:0]   sel_i,
  input  logic [DATA_W-1:0] len_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic              fwd_i,
  input  logic [BUSY_W-1:0] busy_i,
  input  logic              done_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] field [NREG];

  assign field[IDX_NONE] = '0;
  assign field[IDX_LEN]  = len_i;
  assign field[IDX_SRC]  = src_i;
  assign field[IDX_DST]  = dst_i;
  assign field[IDX_FWD]  = DATA_W'(fwd_i);
  assign field[IDX_BUSY] = DATA_W'(busy_i);
  assign field[IDX_DONE] = DATA_W'(done_i);

  // and-or selection over the one-hot select lines
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < int'(NREG); i++) begin
      rdata_o = rdata_o | (field[i] & {DATA_W{sel_i[i]}});
    end
  end

endmodule

// File: rtl/dma_cfg_front.sv
module dma_cfg_front
  import dma_cfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BUSY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic              bus_gnt_o,
  output logic              bus_rvalid_o,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              xfer_valid_o,
  input  logic              xfer_ready_i,
  output logic [DATA_W-1:0] xfer_src_o,
  output logic [DATA_W-1:0] xfer_dst_o,
  output logic [DATA_W-1:0] xfer_len_o,
  input  logic [BUSY_W-1:0] busy_i,
  input  logic              done_i
);

  logic [NREG-1:0]   sel;
  logic              wr, rd;
  logic              src_en, dst_en, wr_len;
  logic [DATA_W-1:0] src_q, dst_q;
  logic              fwd_q, done_q, lock;
  logic [DATA_W-1:0] mux_data;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q, rdata_d;

  assign wr = bus_req_i & bus_we_i;
  assign rd = bus_req_i & ~bus_we_i;

  dma_cfg_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  assign src_en = wr & sel[IDX_SRC];
  assign dst_en = wr & sel[IDX_DST];
  assign wr_len = wr & sel[IDX_LEN];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
    end else if (src_en) begin
      src_q <= bus_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dst_q <= '0;
    end else if (dst_en) begin
      dst_q <= bus_wdata_i;
    end
  end

  dma_cfg_launch #(.DATA_W(DATA_W)) u_launch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_len_i (wr_len),
    .wdata_i  (bus_wdata_i),
    .src_i    (src_q),
    .dst_i    (dst_q),
    .ready_i  (xfer_ready_i),
    .done_i   (done_i),
    .valid_o  (xfer_valid_o),
    .src_o    (xfer_src_o),
    .dst_o    (xfer_dst_o),
    .len_o    (xfer_len_o),
    .fwd_o    (fwd_q),
    .done_o   (done_q),
    .lock_o   (lock)
  );

  dma_cfg_rdmux #(.DATA_W(DATA_W), .BUSY_W(BUSY_W)) u_rdmux (
    .sel_i   (sel),
    .len_i   (xfer_len_o),
    .src_i   (src_q),
    .dst_i   (dst_q),
    .fwd_i   (fwd_q),
    .busy_i  (busy_i),
    .done_i  (done_q),
    .rdata_o (mux_data)
  );

  assign bus_gnt_o = bus_req_i;

  always_comb begin
    rdata_d = rd ? mux_data : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= bus_req_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (bus_req_i) begin
      rdata_q <= rdata_d;
    end
  end

  assign bus_rvalid_o = rvalid_q;
  assign bus_rdata_o  = rdata_q;

endmodule

// File: rtl/dma_cfg_front_chk.sv
module dma_cfg_front_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_req_i,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic              bus_gnt_o,
  input logic              bus_rvalid_o,
  input logic              xfer_valid_o,
  input logic              xfer_ready_i,
  input logic [DATA_W-1:0] xfer_src_o,
  input logic [DATA_W-1:0] xfer_dst_o,
  input logic [DATA_W-1:0] xfer_len_o,
  input logic              done_i,
  input logic              fwd,
  input logic              done_flag,
  input logic              lock
);

  logic len_hit;
  assign len_hit = bus_req_i && bus_we_i && (bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(1));

  p_gnt_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |-> bus_gnt_o);

  p_rvalid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_i |=> bus_rvalid_o);

  p_no_rvalid_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_req_i |=> !bus_rvalid_o);

  p_launch_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_hit && !lock) |=> xfer_valid_o);

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && !xfer_ready_i) |=>
      (xfer_valid_o && $stable(xfer_src_o) && $stable(xfer_dst_o) && $stable(xfer_len_o)));

  p_fwd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_valid_o && xfer_ready_i) |=> (fwd && !xfer_valid_o));

  p_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd && done_i && !len_hit) |=> done_flag);

  p_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len_hit && lock && !xfer_valid_o) |=> (!xfer_valid_o && $stable(xfer_len_o)));

endmodule

bind dma_cfg_front dma_cfg_front_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bus_req_i    (bus_req_i),
  .bus_we_i     (bus_we_i),
  .bus_addr_i   (bus_addr_i),
  .bus_gnt_o    (bus_gnt_o),
  .bus_rvalid_o (bus_rvalid_o),
  .xfer_valid_o (xfer_valid_o),
  .xfer_ready_i (xfer_ready_i),
  .xfer_src_o   (xfer_src_o),
  .xfer_dst_o   (xfer_dst_o),
  .xfer_len_o   (xfer_len_o),
  .done_i       (done_i),
  .fwd          (fwd_q),
  .done_flag    (done_q),
  .lock         (lock)
);

// File: tb/dma_cfg_front_bench.sv
module dma_cfg_front_bench;

  logic        clk;
  logic        rst_n;
  logic        req, we;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        gnt, rvalid;
  logic [31:0] rdata;
  logic        xvalid, xready;
  logic [31:0] xsrc, xdst, xlen;
  logic [7:0]  busy;
  logic        done;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  dma_cfg_front u_dma_cfg_front (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bus_req_i    (req),
    .bus_we_i     (we),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_gnt_o    (gnt),
    .bus_rvalid_o (rvalid),
    .bus_rdata_o  (rdata),
    .xfer_valid_o (xvalid),
    .xfer_ready_i (xready),
    .xfer_src_o   (xsrc),
    .xfer_dst_o   (xdst),
    .xfer_len_o   (xlen),
    .busy_i       (busy),
    .done_i       (done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_src, m_dst, m_len, m_psrc, m_pdst;
  bit m_pend, m_fwd, m_done, m_rvalid;
  logic [31:0] m_rdata;
  int m_ridx;

  function automatic logic [31:0] m_read(input int idx);
    case (idx)
      1: return m_len;
      2: return m_src;
      3: return m_dst;
      4: return {31'd0, m_fwd};
      5: return {24'd0, busy};
      6: return {31'd0, m_done};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rtag(input int idx);
    case (idx)
      1, 2, 3: return "R2";
      4: return "R6";
      5: return "R7";
      6: return "R8";
      default: return "R3";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_len = 0; m_psrc = 0; m_pdst = 0;
      m_pend = 0; m_fwd = 0; m_done = 0; m_rvalid = 0; m_rdata = 0; m_ridx = 0;
    end else begin
      int idx;
      bit lock, launch, hs;
      idx = int'(addr >> 2);
      m_rvalid = req;
      if (req) begin
        m_rdata = we ? 32'd0 : m_read(idx);
        m_ridx = we ? 1 : idx;
      end
      lock = m_pend || (m_fwd && !m_done);
      launch = req && we && idx == 1 && !lock;
      hs = m_pend && xready;
      if (launch) begin
        m_pend = 1; m_fwd = 0; m_done = 0;
        m_len = wdata; m_psrc = m_src; m_pdst = m_dst;
      end else begin
        if (m_fwd && done) m_done = 1;
        if (hs) begin m_pend = 0; m_fwd = 1; end
      end
      if (req && we && idx == 2) m_src = wdata;
      if (req && we && idx == 3) m_dst = wdata;
    end
    #5;
    if (rst_n) begin
      check("R1 gnt", {31'd0, gnt}, {31'd0, req});
      check("R1 rvalid", {31'd0, rvalid}, {31'd0, m_rvalid});
      if (m_rvalid) check({rtag(m_ridx), " rdata"}, rdata, m_rdata);
      check("R4 R9 valid", {31'd0, xvalid}, {31'd0, m_pend});
      if (m_pend) begin
        check("R5 src", xsrc, m_psrc);
        check("R5 dst", xdst, m_pdst);
        check("R5 len", xlen, m_len);
      end
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0; addr = 0; wdata = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = a;
    @(negedge clk);
    req = 0; addr = 0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d;
    req = 0; we = 0; addr = 0; wdata = 0; xready = 0; busy = 0; done = 0;
    rst_n = 0;
    idle(3);
    rst_n = 1;
    idle(1);

    // reset state
    check("R4 reset valid", {31'd0, xvalid}, 32'd0);
    rd(12'h004, d); check("R2 reset len", d, 32'd0);
    rd(12'h008, d); check("R2 reset src", d, 32'd0);
    rd(12'h018, d); check("R8 reset done", d, 32'd0);
    rd(12'h010, d); check("R6 reset fwd", d, 32'd0);

    // programming, with ignored low address bits
    wr(12'h009, 32'h1000_0000);
    wr(12'h00F, 32'h2000_0040);
    rd(12'h00A, d); check("R2 src", d, 32'h1000_0000);
    rd(12'h00C, d); check("R2 dst", d, 32'h2000_0040);

    // launch with ready low, hold, ignored relaunch
    wr(12'h004, 32'd16);
    check("R4 valid", {31'd0, xvalid}, 32'd1);
    check("R4 len", xlen, 32'd16);
    check("R4 src", xsrc, 32'h1000_0000);
    idle(3);
    check("R5 still valid", {31'd0, xvalid}, 32'd1);
    wr(12'h004, 32'd99);
    check("R9 pending len", xlen, 32'd16);
    wr(12'h008, 32'h3000_0000);
    check("R5 src frozen", xsrc, 32'h1000_0000);
    xready = 1;
    idle(1);
    xready = 0;
    check("R6 handshake drops valid", {31'd0, xvalid}, 32'd0);
    rd(12'h010, d); check("R6 fwd set", d, 32'd1);
    rd(12'h018, d); check("R8 not done", d, 32'd0);
    wr(12'h004, 32'd55);
    check("R9 no relaunch", {31'd0, xvalid}, 32'd0);
    rd(12'h004, d); check("R9 len kept", d, 32'd16);

    // busy pass-through
    busy = 8'hA5;
    rd(12'h014, d); check("R7 busy", d, 32'h0000_00A5);
    busy = 8'h3C;
    rd(12'h016, d); check("R7 busy 2", d, 32'h0000_003C);

    // writes to read-only registers
    wr(12'h010, 32'h0);
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    rd(12'h010, d); check("R10 fwd", d, 32'd1);
    rd(12'h018, d); check("R10 done", d, 32'd0);

    // completion
    done = 1;
    idle(1);
    done = 0;
    rd(12'h018, d); check("R8 done set", d, 32'd1);
    idle(2);
    rd(12'h018, d); check("R8 sticky", d, 32'd1);

    // second launch with ready already high
    xready = 1;
    wr(12'h004, 32'd7);
    check("R4 second valid", {31'd0, xvalid}, 32'd1);
    check("R4 second src", xsrc, 32'h3000_0000);
    idle(1);
    xready = 0;
    rd(12'h010, d); check("R6 fwd again", d, 32'd1);
    rd(12'h018, d); check("R8 cleared by launch", d, 32'd0);
    rd(12'h004, d); check("R2 len", d, 32'd7);

    // unmapped indexes
    wr(12'h000, 32'hDEAD_BEEF);
    wr(12'h01C, 32'hDEAD_BEEF);
    wr(12'h400, 32'hDEAD_BEEF);
    rd(12'h000, d); check("R3 idx0", d, 32'd0);
    rd(12'h01C, d); check("R3 idx7", d, 32'd0);
    rd(12'hFFC, d); check("R3 high", d, 32'd0);
    rd(12'h008, d); check("R3 src untouched", d, 32'h3000_0000);
    rd(12'h00C, d); check("R3 dst untouched", d, 32'h2000_0040);

    idle(3);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule